// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block keeps a small set of outbound translation windows and applies them to CPU-side addresses. Software reaches every window through one shared group of registers. A viewport register picks the window that this group currently refers to. A window is described by a 64-bit base, the low 32 bits of its last address, a 64-bit target and a transaction kind. The kind is memory, I/O, configuration type 0 or configuration type 1.

On the translation side, a 64-bit address is compared against every enabled window. When a window matches, the block returns the address moved into that window's target range, together with the window's kind and index. For the two configuration kinds it also returns the bus, device and function numbers carried in the target. When no window matches, the address goes through unchanged and the hit flag stays low. Results appear one clock after the address is presented.

Top module: `atu_outbound_xlate`

## Requirements
- R1: After a synchronous reset every window is disabled, every register reads zero, and the translation outputs show a miss.
- R2: The viewport sits at offset 0x900. Bit 31 selects the direction (1 inbound, 0 outbound) and bits [VP_IDX_W-1:0] hold the window index. Reads return those two fields and zero elsewhere.
- R3: The window registers of the selected window are mapped as follows, and all unlisted bits and unmapped offsets read zero:
  - 0x904: kind in bits [2:0]
  - 0x908: enable in bit 31
  - 0x90C and 0x910: base, low and high words
  - 0x914: limit
  - 0x918 and 0x91C: target, low and high words
- R4: While the viewport selects inbound, or an index of NUM_WIN or more, writes to 0x904 to 0x91C change nothing and reads of them return zero.
- R5: An enable written to 0x908 is already visible in a read of 0x908 on the very next cycle.
- R6: An address hits a window when all of these hold: the window is enabled, address[63:32] equals the base high word, and address[31:0] lies between the base low word and the limit, both ends included.
- R7: On a hit, the address output one cycle later equals the target plus (address[31:0] minus the base low word), computed over 64 bits.
- R8: When several windows hit, the one with the lowest index is reported.
- R9: On a miss, the output address equals the input address and the hit, kind, index, bus, device and function outputs are zero.
- R10: On a hit, the kind output carries the window's kind field (0 memory, 2 I/O, 4 config type 0, 5 config type 1).
- R11: On a hit with kind 4 or 5, the bus, device and function outputs take target bits [31:24], [23:19] and [18:16]. For any other kind they are zero.
- R12: A disabled window never hits, whatever address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| xl_addr_in | input | 64 | CPU-side address to translate |
| xl_addr_out | output | 64 | Translated or passed-through address |
| xl_hit | output | 1 | A window matched |
| xl_type | output | 3 | Kind of the matching window |
| xl_region | output | RIDX_W | Index of the matching window |
| xl_bus | output | 8 | Bus number for configuration hits |
| xl_dev | output | 5 | Device number for configuration hits |
| xl_fn | output | 3 | Function number for configuration hits |

## Verification
The hardest case to reach from the ports is the overlap between windows. Here an address falls inside two enabled windows, and the lower index must win even though both compare units fire. The stimulus programs two windows whose low-word ranges overlap but do not match, and sweeps addresses across every edge of both ranges under three high-word values. It repeats the sweep with each window alone enabled and with neither enabled. Writes through an inbound or out-of-range viewport are then aimed at the enable bit, and a translation check confirms they had no effect.

// File: rtl/atu_pkg.sv
package atu_pkg;

    localparam logic [11:0] OFF_VIEW   = 12'h900;
    localparam logic [11:0] OFF_KIND   = 12'h904;
    localparam logic [11:0] OFF_ENA    = 12'h908;
    localparam logic [11:0] OFF_BASE_L = 12'h90C;
    localparam logic [11:0] OFF_BASE_H = 12'h910;
    localparam logic [11:0] OFF_LIMIT  = 12'h914;
    localparam logic [11:0] OFF_TGT_L  = 12'h918;
    localparam logic [11:0] OFF_TGT_H  = 12'h91C;

    typedef enum logic [2:0] {
        XK_MEM  = 3'd0,
        XK_IO   = 3'd2,
        XK_CFG0 = 3'd4,
        XK_CFG1 = 3'd5
    } xlt_kind_e;

    typedef struct packed {
        logic        en;
        logic [2:0]  kind;
        logic [31:0] base_lo;
        logic [31:0] base_hi;
        logic [31:0] limit;
        logic [31:0] tgt_lo;
        logic [31:0] tgt_hi;
    } win_cfg_t;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
    } bdf_t;

    function automatic logic kind_is_cfg(logic [2:0] k);
        return (k == XK_CFG0) || (k == XK_CFG1);
    endfunction

    function automatic logic addr_in_window(win_cfg_t w, logic [63:0] a);
        return w.en && (a[63:32] == w.base_hi) &&
               (a[31:0] >= w.base_lo) && (a[31:0] <= w.limit);
    endfunction

    function automatic logic [63:0] move_addr(win_cfg_t w, logic [63:0] a);
        logic [31:0] off;
        off = a[31:0] - w.base_lo;
        return {w.tgt_hi, w.tgt_lo} + {32'h0, off};
    endfunction

    function automatic bdf_t bdf_of(win_cfg_t w);
        bdf_t b;
        b.bus = w.tgt_lo[31:24];
        b.dev = w.tgt_lo[23:19];
        b.fn  = w.tgt_lo[18:16];
        return b;
    endfunction

endpackage

// File: rtl/atu_regfile.sv
module atu_regfile
    import atu_pkg::*;
#(
    parameter int NUM_WIN  = 2,
    parameter int VP_IDX_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [11:0]                addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    output win_cfg_t [NUM_WIN-1:0]     cfg
);

    logic                 vp_dir;
    logic [VP_IDX_W-1:0]  vp_idx;
    logic                 sel_ok;
    win_cfg_t             cur;
    win_cfg_t [NUM_WIN-1:0] cfg_q;

    assign sel_ok = !vp_dir && (int'(vp_idx) < NUM_WIN);
    assign cfg    = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vp_dir <= 1'b0;
            vp_idx <= '0;
        end else if (wr && addr == OFF_VIEW) begin
            vp_dir <= wdata[31];
            vp_idx <= wdata[VP_IDX_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (wr && sel_ok && vp_idx == VP_IDX_W'(g)) begin
                case (addr)
                    OFF_KIND:   cfg_q[g].kind    <= wdata[2:0];
                    OFF_ENA:    cfg_q[g].en      <= wdata[31];
                    OFF_BASE_L: cfg_q[g].base_lo <= wdata;
                    OFF_BASE_H: cfg_q[g].base_hi <= wdata;
                    OFF_LIMIT:  cfg_q[g].limit   <= wdata;
                    OFF_TGT_L:  cfg_q[g].tgt_lo  <= wdata;
                    OFF_TGT_H:  cfg_q[g].tgt_hi  <= wdata;
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (sel_ok && vp_idx == VP_IDX_W'(i)) cur = cfg_q[i];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_VIEW:   rdata = {vp_dir, 31'h0} | 32'(vp_idx);
            OFF_KIND:   rdata = {29'h0, cur.kind};
            OFF_ENA:    rdata = {cur.en, 31'h0};
            OFF_BASE_L: rdata = cur.base_lo;
            OFF_BASE_H: rdata = cur.base_hi;
            OFF_LIMIT:  rdata = cur.limit;
            OFF_TGT_L:  rdata = cur.tgt_lo;
            OFF_TGT_H:  rdata = cur.tgt_hi;
            default:    rdata = '0;
        endcase
    end

    // R4
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !sel_ok && addr != OFF_VIEW) |=> $stable(cfg_q));

    // R5
    enable_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel_ok && addr == OFF_ENA) |=> (cur.en == $past(wdata[31])));

endmodule

// File: rtl/atu_match.sv
module atu_match
    import atu_pkg::*;
#(
    parameter int NUM_WIN = 2
) (
    input  logic [63:0]               addr,
    input  win_cfg_t [NUM_WIN-1:0]    cfg,
    output logic [NUM_WIN-1:0]        match_vec,
    output logic [NUM_WIN-1:0][63:0]  moved,
    output logic [NUM_WIN-1:0][2:0]   kind,
    output bdf_t [NUM_WIN-1:0]        bdf
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign match_vec[g] = addr_in_window(cfg[g], addr);
        assign moved[g]     = move_addr(cfg[g], addr);
        assign kind[g]      = cfg[g].kind;
        assign bdf[g]       = kind_is_cfg(cfg[g].kind) ? bdf_of(cfg[g]) : '0;
    end

endmodule

// File: rtl/atu_select.sv
module atu_select
    import atu_pkg::*;
#(
    parameter int NUM_WIN = 2,
    localparam int RIDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [63:0]               addr,
    input  logic [NUM_WIN-1:0]        match_vec,
    input  logic [NUM_WIN-1:0][63:0]  moved,
    input  logic [NUM_WIN-1:0][2:0]   kind,
    input  bdf_t [NUM_WIN-1:0]        bdf,
    output logic [63:0]               out_addr,
    output logic                      out_hit,
    output logic [2:0]                out_kind,
    output logic [RIDX_W-1:0]         out_region,
    output bdf_t                      out_bdf
);

    logic [RIDX_W-1:0] pick;
    logic              any;

    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                pick = RIDX_W'(i);
                any  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_addr   <= '0;
            out_hit    <= 1'b0;
            out_kind   <= '0;
            out_region <= '0;
            out_bdf    <= '0;
        end else if (any) begin
            out_addr   <= moved[pick];
            out_hit    <= 1'b1;
            out_kind   <= kind[pick];
            out_region <= pick;
            out_bdf    <= bdf[pick];
        end else begin
            out_addr   <= addr;
            out_hit    <= 1'b0;
            out_kind   <= '0;
            out_region <= '0;
            out_bdf    <= '0;
        end
    end

    // R6
    hit_follows_match_chk: assert property (@(posedge clk) disable iff (rst)
        (|match_vec) |=> out_hit);

    // R9
    miss_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        !(|match_vec) |=> (!out_hit && out_addr == $past(addr) && out_bdf == '0));

    // R8
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|match_vec) |=> ((($past(match_vec) >> out_region) & NUM_WIN'(1)) == NUM_WIN'(1) &&
                          ($past(match_vec) & ((NUM_WIN'(1) << out_region) - NUM_WIN'(1))) == '0));

endmodule

// File: rtl/atu_outbound_xlate.sv
module atu_outbound_xlate
    import atu_pkg::*;
#(
    parameter int NUM_WIN  = 2,
    parameter int VP_IDX_W = 4,
    localparam int RIDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [63:0]       xl_addr_in,
    output logic [63:0]       xl_addr_out,
    output logic              xl_hit,
    output logic [2:0]        xl_type,
    output logic [RIDX_W-1:0] xl_region,
    output logic [7:0]        xl_bus,
    output logic [4:0]        xl_dev,
    output logic [2:0]        xl_fn
);

    win_cfg_t [NUM_WIN-1:0]    win_cfg;
    logic [NUM_WIN-1:0]        match_vec;
    logic [NUM_WIN-1:0][63:0]  moved;
    logic [NUM_WIN-1:0][2:0]   kind;
    bdf_t [NUM_WIN-1:0]        bdf;
    bdf_t                      out_bdf;

    atu_regfile #(.NUM_WIN(NUM_WIN), .VP_IDX_W(VP_IDX_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (win_cfg)
    );

    atu_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr      (xl_addr_in),
        .cfg       (win_cfg),
        .match_vec (match_vec),
        .moved     (moved),
        .kind      (kind),
        .bdf       (bdf)
    );

    atu_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .addr       (xl_addr_in),
        .match_vec  (match_vec),
        .moved      (moved),
        .kind       (kind),
        .bdf        (bdf),
        .out_addr   (xl_addr_out),
        .out_hit    (xl_hit),
        .out_kind   (xl_type),
        .out_region (xl_region),
        .out_bdf    (out_bdf)
    );

    assign xl_bus = out_bdf.bus;
    assign xl_dev = out_bdf.dev;
    assign xl_fn  = out_bdf.fn;

endmodule

// File: tb/tb_atu_outbound_xlate.sv
module tb_atu_outbound_xlate;

    localparam int NW = 2;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [63:0] xl_addr_in;
    logic [63:0] xl_addr_out;
    logic        xl_hit;
    logic [2:0]  xl_type;
    logic [0:0]  xl_region;
    logic [7:0]  xl_bus;
    logic [4:0]  xl_dev;
    logic [2:0]  xl_fn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_en   [NW];
    logic [2:0]  m_kind [NW];
    logic [31:0] m_blo [NW], m_bhi [NW], m_lim [NW], m_tlo [NW], m_thi [NW];

    always #HALF clk = ~clk;

    atu_outbound_xlate dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xl_addr_in(xl_addr_in),
        .xl_addr_out(xl_addr_out), .xl_hit(xl_hit), .xl_type(xl_type),
        .xl_region(xl_region), .xl_bus(xl_bus), .xl_dev(xl_dev), .xl_fn(xl_fn)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(req, {32'h0, cfg_rdata}, {32'h0, exp});
    endtask

    task automatic prog(input int w, input logic [2:0] k, input logic [63:0] base,
                        input logic [31:0] lim, input logic [63:0] tgt);
        wr(12'h900, 32'(w));
        wr(12'h904, {29'h0, k});
        wr(12'h90C, base[31:0]);
        wr(12'h910, base[63:32]);
        wr(12'h914, lim);
        wr(12'h918, tgt[31:0]);
        wr(12'h91C, tgt[63:32]);
        m_kind[w] = k; m_blo[w] = base[31:0]; m_bhi[w] = base[63:32];
        m_lim[w] = lim; m_tlo[w] = tgt[31:0]; m_thi[w] = tgt[63:32];
    endtask

    task automatic set_en(input int w, input logic e);
        wr(12'h900, 32'(w));
        wr(12'h908, {e, 31'h0});
        m_en[w] = e;
    endtask

    // Expected result from R6..R12
    task automatic xl_check(input logic [63:0] a);
        logic        eh;
        int          er;
        logic [63:0] ea;
        logic [2:0]  ek;
        logic [15:0] eb;
        eh = 1'b0; er = 0; ea = a; ek = 3'd0; eb = 16'h0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (m_en[i] && a[63:32] == m_bhi[i] && a[31:0] >= m_blo[i] && a[31:0] <= m_lim[i]) begin
                eh = 1'b1; er = i; ek = m_kind[i];
                ea = {m_thi[i], m_tlo[i]} + 64'(a[31:0] - m_blo[i]);
                eb = (m_kind[i] == 3'd4 || m_kind[i] == 3'd5) ? m_tlo[i][31:16] : 16'h0;
            end
        end
        @(negedge clk);
        xl_addr_in = a;
        @(negedge clk);
        chk("R6 hit", {63'h0, xl_hit}, {63'h0, eh});
        chk("R7/R9 address", xl_addr_out, ea);
        chk("R8 region", {63'h0, xl_region}, 64'(er));
        chk("R10 kind", {61'h0, xl_type}, {61'h0, ek});
        chk("R11 bdf", {48'h0, xl_bus, xl_dev, xl_fn}, {48'h0, eb});
    endtask

    task automatic sweep();
        logic [31:0] pts [14];
        pts[0] = m_blo[0] - 1; pts[1] = m_blo[0]; pts[2] = m_blo[0] + 1;
        pts[3] = m_lim[0] - 1; pts[4] = m_lim[0]; pts[5] = m_lim[0] + 1;
        pts[6] = m_blo[1] - 1; pts[7] = m_blo[1]; pts[8] = m_blo[1] + 1;
        pts[9] = m_lim[1] - 1; pts[10] = m_lim[1]; pts[11] = m_lim[1] + 1;
        pts[12] = 32'h0; pts[13] = 32'hFFFF_FFFF;
        for (int h = 0; h < 3; h++) begin
            for (int p = 0; p < 14; p++) xl_check({32'(h), pts[p]});
            for (int s = 0; s < 8; s++) xl_check({32'h1, m_blo[0] + 32'(s) * 32'h0000_2345});
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_en[i] = 0; m_kind[i] = 0; m_blo[i] = 0; m_bhi[i] = 0;
            m_lim[i] = 0; m_tlo[i] = 0; m_thi[i] = 0;
        end
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = 12'h0; cfg_wdata = 32'h0;
        xl_addr_in = 64'h0000_0001_8000_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 hit", {63'h0, xl_hit}, 64'h0);
        rd("R1 viewport", 12'h900, 32'h0);
        rd("R1 enable", 12'h908, 32'h0);
        rd("R1 base", 12'h90C, 32'h0);

        // R2 viewport fields
        wr(12'h900, 32'h8000_FFF1);
        rd("R2 viewport", 12'h900, 32'h8000_0001);

        // R3 register map on window 1
        wr(12'h900, 32'h1);
        wr(12'h904, 32'hFFFF_FFFF);
        rd("R3 kind", 12'h904, 32'h7);
        wr(12'h908, 32'hFFFF_FFFF);
        rd("R3 enable", 12'h908, 32'h8000_0000);
        wr(12'h908, 32'h0);
        wr(12'h91C, 32'hCAFE_0001);
        rd("R3 target high", 12'h91C, 32'hCAFE_0001);
        rd("R3 unmapped", 12'h920, 32'h0);

        // Program windows: overlapping low-word ranges, same high word
        prog(0, 3'd0, 64'h0000_0001_8000_0000, 32'h8000_FFFF, 64'h0000_00AB_0000_0000);
        prog(1, 3'd4, 64'h0000_0001_8000_8000, 32'h8001_0FFF, 64'h0000_0000_3CAE_0000);
        rd("R3 limit", 12'h914, 32'h8001_0FFF);
        rd("R3 target low", 12'h918, 32'h3CAE_0000);

        // R12 nothing enabled
        sweep();

        // R5 enable visible next cycle
        wr(12'h900, 32'h0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 12'h908; cfg_wdata = 32'h8000_0000;
        @(negedge clk);
        cfg_wr = 1'b0;
        rd("R5 enable readback", 12'h908, 32'h8000_0000);
        m_en[0] = 1'b1;
        sweep();

        // R8 both enabled
        set_en(1, 1'b1);
        sweep();

        // R12 window 0 disabled, window 1 alone (config type 0)
        set_en(0, 1'b0);
        sweep();

        // R4 inbound and out-of-range selection
        wr(12'h900, 32'h8000_0000);
        wr(12'h908, 32'h8000_0000);
        wr(12'h90C, 32'h1234_5678);
        rd("R4 inbound read", 12'h90C, 32'h0);
        wr(12'h900, 32'h0000_0003);
        wr(12'h908, 32'h8000_0000);
        rd("R4 range read", 12'h908, 32'h0);
        wr(12'h900, 32'h0);
        rd("R4 base kept", 12'h90C, 32'h8000_0000);
        rd("R4 enable kept", 12'h908, 32'h0);
        xl_check(64'h0000_0001_8000_0010);

        // R10/R11 type 1 config and I/O kinds
        prog(1, 3'd5, 64'h0000_0001_8000_8000, 32'h8001_0FFF, 64'h0000_0000_FFF8_0000);
        prog(0, 3'd2, 64'h0000_0001_8000_0000, 32'h8000_FFFF, 64'h0000_0000_0001_0000);
        set_en(0, 1'b1);
        sweep();

        // R1 reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NW; i++) m_en[i] = 1'b0;
        rd("R1 viewport after reset", 12'h900, 32'h0);
        xl_check(64'h0000_0001_8000_0010);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule